// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block drives the pad controls for a bank of quasi-bidirectional pins that a processor writes through output latches. Each pin gets three enables: a strong pull-down, a strong pull-up that is held for a short time only, and a weak pull-up keeper. Writing a 0 pulls the pin low hard. Writing a 1 over a 0 switches on the strong pull-up for a fixed number of oscillator cycles so that the pin rises fast. After that only the keeper holds the pin high, so an outside device can still pull it low.

The pins fall into four groups, and each group has its own write strobe and data word. The main scan group gives a two-cycle pulse and reads back its latch. The auxiliary group (extra scan outputs and general-purpose I/O) gives a one-cycle pulse and reads back the pin level. The serial pair gives a two-cycle pulse and reads back either the latch or the pin, as chosen by a select input that stands for the type of access. The LED group is plain open-drain and reads back its latch. All timing counts clock cycles of `clk`, which is the oscillator clock.

Top module: `qbd_port_ctrl`

## Requirements
- R1: A pin whose latch holds 0 has its pull-down enable at 1 and both pull-up enables at 0 from the clock edge that stored the 0.
- R2: On the main and serial groups, a write that changes a latch bit from 0 to 1 holds that pin's strong pull-up enable at 1 for exactly 2 clock cycles after the write edge. The weak pull-up enable is 1 for as long as the latch holds 1.
- R3: On the auxiliary group, the same 0-to-1 change holds the strong pull-up enable at 1 for exactly 1 clock cycle.
- R4: The main group read data equals its latch contents, whatever the pin levels.
- R5: The auxiliary group read data equals `aux_pin_in`, whatever the latch holds.
- R6: For an LED pin, latch 0 gives pull-down only and latch 1 gives weak pull-up only. The strong pull-up enable is never 1, and the read data equals the latch.
- R7: Serial pair read data equals `ser_pin_in` when `ser_rd_pin` is 1, and the latch when `ser_rd_pin` is 0.
- R8: Writing 1 to a bit that already holds 1 does not start a new strong pull-up pulse.
- R9: After reset every latch holds 1. Every pin then has only its weak pull-up enabled, and no pulse is running.
- R10: Writing 0 to a pin during its strong pull-up pulse ends the pulse at the same edge: from that edge the strong enable is 0 and the pull-down enable is 1.
- R11: Pulses are per pin. In a group write, only the bits that change from 0 to 1 pulse, and the other bits of the same group are not affected.
- R12: Pad vector bit order from bit 0 upward is: main pins, then auxiliary pins, then the serial pair, then the LED pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_we | input | 1 | Write strobe, main scan group |
| main_wdata | input | N_MAIN | Write data, main scan group |
| main_rdata | output | N_MAIN | Read data, main group (latch) |
| aux_we | input | 1 | Write strobe, auxiliary group |
| aux_wdata | input | N_AUX | Write data, auxiliary group |
| aux_pin_in | input | N_AUX | Pin levels, auxiliary group |
| aux_rdata | output | N_AUX | Read data, auxiliary group (pin) |
| ser_we | input | 1 | Write strobe, serial pair |
| ser_wdata | input | N_SER | Write data, serial pair |
| ser_pin_in | input | N_SER | Pin levels, serial pair |
| ser_rd_pin | input | 1 | 1 reads pins, 0 reads latch |
| ser_rdata | output | N_SER | Read data, serial pair |
| led_we | input | 1 | Write strobe, LED group |
| led_wdata | input | N_LED | Write data, LED group |
| led_rdata | output | N_LED | Read data, LED group (latch) |
| pad_pd_en | output | NP | Strong pull-down enables |
| pad_spu_en | output | NP | Momentary strong pull-up enables |
| pad_wpu_en | output | NP | Weak pull-up keeper enables |

## Verification
The hardest case to reach is a pulse that is cut short or re-driven partway through: a 0 written in the single cycle between the two strong-drive cycles, or a 1 rewritten over a 1 while the counter still runs. Directed sequences write a group on back-to-back cycles to land on those edges. A long run of random writes with mixed bit patterns then hits the same edges on single bits of a group while neighbouring bits rise. A behavioural model that keeps one integer counter per pin predicts every pad enable and every read word on every cycle.

// File: rtl/qbd_pkg.sv
package qbd_pkg;

  typedef enum logic [1:0] {
    RD_LATCH  = 2'd0,
    RD_PIN    = 2'd1,
    RD_EITHER = 2'd2
  } rd_src_e;

  // a write that takes a latch bit from 0 to 1
  function automatic logic rise_evt(input logic we, input logic d, input logic q);
    return we & d & ~q;
  endfunction

  // next value of the strong-drive counter of one pin
  function automatic int unsigned cnt_next(input logic we, input logic d, input logic q,
                                           input int unsigned cur, input int unsigned len);
    if (we && d && !q) return len;
    if (we && !d)      return 0;
    if (cur != 0)      return cur - 1;
    return 0;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/qbd_pin_cell.sv
module qbd_pin_cell #(
  parameter int unsigned PULSE = 2,
  parameter int unsigned CW    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q_o,
  output logic pd_en,
  output logic spu_en,
  output logic wpu_en
);

  logic          q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;

  // named events for the checks below
  wire rise_w   = qbd_pkg::rise_evt(we, d, q);
  wire pulse_w  = q & (cnt != '0);
  wire cancel_w = pulse_w & we & ~d;
  wire rewr_w   = we & d & q & (cnt == '0);

  always_comb cnt_d = CW'(qbd_pkg::cnt_next(we, d, q, 32'(cnt), PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b1;
      cnt <= '0;
    end else begin
      if (we) q <= d;
      cnt <= cnt_d;
    end
  end

  assign q_o    = q;
  assign pd_en  = ~q;
  assign spu_en = pulse_w;
  assign wpu_en = q;

  p_low_pd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !d) |=> (pd_en && !spu_en && !wpu_en));

  p_no_retrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rewr_w |=> !spu_en);

  p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_w |=> (!spu_en && pd_en));

  if (PULSE > 0) begin : g_pulse_chk
    p_pulse_start_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_w |=> spu_en);
    p_pulse_end_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_w && cnt == CW'(1) && !we) |=> !spu_en);
  end

endmodule

// File: rtl/qbd_group.sv
module qbd_group #(
  parameter int unsigned      N      = 8,
  parameter int unsigned      PULSE  = 2,
  parameter int unsigned      CW     = 2,
  parameter qbd_pkg::rd_src_e RD_SRC = qbd_pkg::RD_LATCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pin_in,
  input  logic         rd_pin,
  output logic [N-1:0] pd_en,
  output logic [N-1:0] spu_en,
  output logic [N-1:0] wpu_en,
  output logic [N-1:0] rdata
);

  localparam logic FIX_PIN = (RD_SRC == qbd_pkg::RD_PIN);
  localparam logic ANY_SEL = (RD_SRC == qbd_pkg::RD_EITHER);

  logic [N-1:0] lat;
  logic         sel_pin;

  for (genvar i = 0; i < N; i++) begin : g_pin
    qbd_pin_cell #(.PULSE(PULSE), .CW(CW)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .d      (wdata[i]),
      .q_o    (lat[i]),
      .pd_en  (pd_en[i]),
      .spu_en (spu_en[i]),
      .wpu_en (wpu_en[i])
    );
  end

  always_comb begin
    sel_pin = FIX_PIN | (ANY_SEL & rd_pin);
    rdata   = sel_pin ? pin_in : lat;
  end

  if (RD_SRC == qbd_pkg::RD_LATCH) begin : g_latch_chk
    p_rd_latch_r4_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we) |-> (rdata == $past(wdata)));
  end

endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl #(
  parameter int unsigned N_MAIN     = 16,
  parameter int unsigned N_AUX      = 4,
  parameter int unsigned N_SER      = 2,
  parameter int unsigned N_LED      = 4,
  parameter int unsigned MAIN_PULSE = 2,
  parameter int unsigned AUX_PULSE  = 1,
  parameter int unsigned SER_PULSE  = 2,
  localparam int unsigned NP = N_MAIN + N_AUX + N_SER + N_LED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_we,
  input  logic [N_MAIN-1:0] main_wdata,
  output logic [N_MAIN-1:0] main_rdata,
  input  logic              aux_we,
  input  logic [N_AUX-1:0]  aux_wdata,
  input  logic [N_AUX-1:0]  aux_pin_in,
  output logic [N_AUX-1:0]  aux_rdata,
  input  logic              ser_we,
  input  logic [N_SER-1:0]  ser_wdata,
  input  logic [N_SER-1:0]  ser_pin_in,
  input  logic              ser_rd_pin,
  output logic [N_SER-1:0]  ser_rdata,
  input  logic              led_we,
  input  logic [N_LED-1:0]  led_wdata,
  output logic [N_LED-1:0]  led_rdata,
  output logic [NP-1:0]     pad_pd_en,
  output logic [NP-1:0]     pad_spu_en,
  output logic [NP-1:0]     pad_wpu_en
);

  localparam int unsigned MAXP = (MAIN_PULSE > AUX_PULSE)
                                 ? ((MAIN_PULSE > SER_PULSE) ? MAIN_PULSE : SER_PULSE)
                                 : ((AUX_PULSE > SER_PULSE) ? AUX_PULSE : SER_PULSE);
  localparam int unsigned CW    = qbd_pkg::cnt_bits(MAXP);
  localparam int unsigned B_AUX = N_MAIN;
  localparam int unsigned B_SER = B_AUX + N_AUX;
  localparam int unsigned B_LED = B_SER + N_SER;

  qbd_group #(.N(N_MAIN), .PULSE(MAIN_PULSE), .CW(CW), .RD_SRC(qbd_pkg::RD_LATCH)) u_main (
    .clk(clk), .rst_n(rst_n), .we(main_we), .wdata(main_wdata),
    .pin_in('0), .rd_pin(1'b0),
    .pd_en (pad_pd_en [B_AUX-1:0]),
    .spu_en(pad_spu_en[B_AUX-1:0]),
    .wpu_en(pad_wpu_en[B_AUX-1:0]),
    .rdata (main_rdata)
  );

  qbd_group #(.N(N_AUX), .PULSE(AUX_PULSE), .CW(CW), .RD_SRC(qbd_pkg::RD_PIN)) u_aux (
    .clk(clk), .rst_n(rst_n), .we(aux_we), .wdata(aux_wdata),
    .pin_in(aux_pin_in), .rd_pin(1'b1),
    .pd_en (pad_pd_en [B_SER-1:B_AUX]),
    .spu_en(pad_spu_en[B_SER-1:B_AUX]),
    .wpu_en(pad_wpu_en[B_SER-1:B_AUX]),
    .rdata (aux_rdata)
  );

  qbd_group #(.N(N_SER), .PULSE(SER_PULSE), .CW(CW), .RD_SRC(qbd_pkg::RD_EITHER)) u_ser (
    .clk(clk), .rst_n(rst_n), .we(ser_we), .wdata(ser_wdata),
    .pin_in(ser_pin_in), .rd_pin(ser_rd_pin),
    .pd_en (pad_pd_en [B_LED-1:B_SER]),
    .spu_en(pad_spu_en[B_LED-1:B_SER]),
    .wpu_en(pad_wpu_en[B_LED-1:B_SER]),
    .rdata (ser_rdata)
  );

  // open-drain LED group: zero pulse length
  qbd_group #(.N(N_LED), .PULSE(0), .CW(CW), .RD_SRC(qbd_pkg::RD_LATCH)) u_led (
    .clk(clk), .rst_n(rst_n), .we(led_we), .wdata(led_wdata),
    .pin_in('0), .rd_pin(1'b0),
    .pd_en (pad_pd_en [NP-1:B_LED]),
    .spu_en(pad_spu_en[NP-1:B_LED]),
    .wpu_en(pad_wpu_en[NP-1:B_LED]),
    .rdata (led_rdata)
  );

  p_led_od_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_spu_en[NP-1:B_LED] == '0);

endmodule

// File: tb/sim_qbd_port_ctrl.sv
module sim_qbd_port_ctrl;
  localparam int NM = 16, NA = 4, NS = 2, NL = 4;
  localparam int NP = NM + NA + NS + NL;
  localparam int BA = NM, BS = NM + NA, BL = NM + NA + NS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          main_we = 0, aux_we = 0, ser_we = 0, led_we = 0, ser_rd_pin = 0;
  logic [NM-1:0] main_wdata = '0;
  logic [NA-1:0] aux_wdata = '0, aux_pin_in = '0;
  logic [NS-1:0] ser_wdata = '0, ser_pin_in = '0;
  logic [NL-1:0] led_wdata = '0;
  logic [NM-1:0] main_rdata;
  logic [NA-1:0] aux_rdata;
  logic [NS-1:0] ser_rdata;
  logic [NL-1:0] led_rdata;
  logic [NP-1:0] pad_pd_en, pad_spu_en, pad_wpu_en;

  qbd_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .main_we(main_we), .main_wdata(main_wdata), .main_rdata(main_rdata),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .aux_pin_in(aux_pin_in), .aux_rdata(aux_rdata),
    .ser_we(ser_we), .ser_wdata(ser_wdata), .ser_pin_in(ser_pin_in),
    .ser_rd_pin(ser_rd_pin), .ser_rdata(ser_rdata),
    .led_we(led_we), .led_wdata(led_wdata), .led_rdata(led_rdata),
    .pad_pd_en(pad_pd_en), .pad_spu_en(pad_spu_en), .pad_wpu_en(pad_wpu_en)
  );

  int checks = 0, errors = 0;
  int m_lat[NP];
  int m_cnt[NP];

  // pulse length per pad index (R2, R3, R6, R12 ordering)
  function automatic int plen(int i);
    if (i < BA) return 2;
    if (i < BS) return 1;
    if (i < BL) return 2;
    return 0;
  endfunction

  function automatic bit wr_of(int i);
    if (i < BA) return main_we;
    if (i < BS) return aux_we;
    if (i < BL) return ser_we;
    return led_we;
  endfunction

  function automatic bit dat_of(int i);
    if (i < BA) return main_wdata[i];
    if (i < BS) return aux_wdata[i-BA];
    if (i < BL) return ser_wdata[i-BS];
    return led_wdata[i-BL];
  endfunction

  task automatic model_tick();
    for (int i = 0; i < NP; i++) begin
      if (!rst_n) begin
        m_lat[i] = 1; m_cnt[i] = 0;
      end else if (wr_of(i) && dat_of(i) && m_lat[i] == 0) begin
        m_lat[i] = 1; m_cnt[i] = plen(i);
      end else if (wr_of(i) && !dat_of(i)) begin
        m_lat[i] = 0; m_cnt[i] = 0;
      end else if (m_cnt[i] > 0) begin
        m_cnt[i] = m_cnt[i] - 1;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NP-1:0] e_pd, e_spu, e_wpu;
    logic [NM-1:0] e_main;
    logic [NL-1:0] e_led;
    logic [NS-1:0] e_ser;
    for (int i = 0; i < NP; i++) begin
      e_pd[i]  = (m_lat[i] == 0);
      e_wpu[i] = (m_lat[i] == 1);
      e_spu[i] = (m_lat[i] == 1) && (m_cnt[i] > 0);
    end
    for (int i = 0; i < NM; i++) e_main[i] = m_lat[i][0];
    for (int i = 0; i < NL; i++) e_led[i]  = m_lat[BL+i][0];
    for (int i = 0; i < NS; i++) e_ser[i]  = ser_rd_pin ? ser_pin_in[i] : m_lat[BS+i][0];
    chk("R1 pull-down enables", 32'(pad_pd_en), 32'(e_pd));
    chk("R2/R3/R10 strong pull-up enables", 32'(pad_spu_en), 32'(e_spu));
    chk("R9 weak pull-up enables", 32'(pad_wpu_en), 32'(e_wpu));
    chk("R4 main read", 32'(main_rdata), 32'(e_main));
    chk("R5 aux read", 32'(aux_rdata), 32'(aux_pin_in));
    chk("R7 serial read", 32'(ser_rdata), 32'(e_ser));
    chk("R6 led read", 32'(led_rdata), 32'(e_led));
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    #2;
    compare_all();
  endtask

  task automatic idle();
    main_we = 0; aux_we = 0; ser_we = 0; led_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_lat[i] = 1; m_cnt[i] = 0; end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9: reset state
    chk("R9 reset weak only", 32'(pad_wpu_en), 32'({NP{1'b1}}));
    chk("R9 reset no strong", 32'(pad_spu_en), 32'h0);

    // R1: write zeros to main
    main_we = 1; main_wdata = '0; step(); idle();
    chk("R1 main low", 32'(pad_pd_en[NM-1:0]), 32'hFFFF);
    // R2: two-cycle pulse
    main_we = 1; main_wdata = 16'hFFFF; step(); idle();
    chk("R2 pulse cycle 1", 32'(pad_spu_en[NM-1:0]), 32'hFFFF);
    step();
    chk("R2 pulse cycle 2", 32'(pad_spu_en[NM-1:0]), 32'hFFFF);
    step();
    chk("R2 pulse over", 32'(pad_spu_en[NM-1:0]), 32'h0);
    // R8: rewrite ones
    main_we = 1; main_wdata = 16'hFFFF; step(); idle();
    chk("R8 no retrigger", 32'(pad_spu_en[NM-1:0]), 32'h0);
    // R3: aux one-cycle pulse
    aux_we = 1; aux_wdata = '0; step();
    aux_wdata = 4'hF; step(); idle();
    chk("R3 aux pulse", 32'(pad_spu_en[BS-1:BA]), 32'hF);
    step();
    chk("R3 aux pulse over", 32'(pad_spu_en[BS-1:BA]), 32'h0);
    // R10: cancel mid pulse
    main_we = 1; main_wdata = '0; step();
    main_wdata = 16'hFFFF; step();
    main_wdata = 16'h0000; step(); idle();
    chk("R10 cancel strong", 32'(pad_spu_en[NM-1:0]), 32'h0);
    chk("R10 cancel pull-down", 32'(pad_pd_en[NM-1:0]), 32'hFFFF);
    // R11: only rising bits pulse
    main_we = 1; main_wdata = 16'h00FF; step(); idle();
    chk("R11 partial pulse", 32'(pad_spu_en[NM-1:0]), 32'h00FF);
    chk("R4 main latch read", 32'(main_rdata), 32'h00FF);
    // R5: aux reads pins
    aux_pin_in = 4'h5; aux_we = 1; aux_wdata = 4'hA; step(); idle();
    chk("R5 aux pin read", 32'(aux_rdata), 32'h5);
    // R7: serial selectable read
    ser_we = 1; ser_wdata = 2'b01; ser_pin_in = 2'b10; ser_rd_pin = 0; step(); idle();
    chk("R7 serial latch read", 32'(ser_rdata), 32'h1);
    ser_rd_pin = 1; step();
    chk("R7 serial pin read", 32'(ser_rdata), 32'h2);
    // R6: LED open-drain
    led_we = 1; led_wdata = 4'h0; step();
    led_wdata = 4'h5; step(); idle();
    chk("R6 led pull-down", 32'(pad_pd_en[NP-1:BL]), 32'hA);
    chk("R6 led weak", 32'(pad_wpu_en[NP-1:BL]), 32'h5);
    chk("R6 led no strong", 32'(pad_spu_en[NP-1:BL]), 32'h0);
    // R12: serial pad position
    chk("R12 serial pads", 32'(pad_pd_en[BL-1:BS]), 32'h2);

    // random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      main_we    = ($urandom % 3) == 0;
      main_wdata = NM'($urandom);
      aux_we     = ($urandom % 3) == 0;
      aux_wdata  = NA'($urandom);
      aux_pin_in = NA'($urandom);
      ser_we     = ($urandom % 3) == 0;
      ser_wdata  = NS'($urandom);
      ser_pin_in = NS'($urandom);
      ser_rd_pin = 1'($urandom);
      led_we     = ($urandom % 3) == 0;
      led_wdata  = NL'($urandom);
      step();
    end
    idle();
    // R9: reset again in mid-run
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R9 reset again", 32'(pad_wpu_en), 32'({NP{1'b1}}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule